// File: doc/BRIEF.md
# HDLC Channel FIFO Controller

This block is the host side of one synchronous B-channel framing engine. Software programs it through a 32-bit control word and observes it through a 32-bit status word. Transmit data is written, and receive data is read, as 32-bit words. In each word the earliest byte on the line occupies bits 7:0. A byte-serial line port stands in for the bit-level flag and stuffing logic. The line asks for transmit bytes one at a time and delivers received bytes one at a time, each with an end marker and a frame-quality indication.

Each direction owns one pool of either 32 or 128 bytes, selected by a mode bit. Transmit blocks are armed through a length byte in the control word, and the value 0 stands for a whole pool. Receive blocks are closed either by a frame end in framed mode or by a full pool. The block raises three latched events: transmit pool ready, transmit underrun and receive pool ready. A status read clears them, and their OR drives an interrupt line. A test loopback routes the transmit byte stream back into the receiver.

Top module: `hdlc_chan_fifo`

## Requirements
- R1: After reset the status word reads 0x0?000080, with transmit-ready (bit 7) set, all other event and frame bits clear, and the version parameter in bits 27:24. The interrupt output is high because transmit-ready is set.
- R2: A control write latches the block length from bits 15:8, the end-of-frame flag from bit 0 and the mode from bits 23:16. The next transmit word push arms a block of that many bytes. A length of 0 arms a full pool: 32 bytes, or 128 when mode bit 5 is set.
- R3: An armed block goes out one byte per line request, in little-endian order inside each word, with exactly the block's byte count. In framed mode (mode bit 1 clear) the last byte of a block flagged end-of-frame carries the line end marker. In transparent mode (mode bit 1 set) no byte carries it.
- R4: Transmit-ready (status bit 7) latches when a block has been fully sent, and also when a control write sets command bit 7 (transmitter reset).
- R5: A line request that arrives while a frame is open but no block is being sent latches underrun (status bit 6). The transmitter then outputs nothing and ignores pushes until a transmitter reset. A frame is open after a framed block without end-of-frame, or after any transparent block. Requests with no open frame are ignored.
- R6: In framed mode a received end marker closes the block and latches receive-ready (status bit 5). It also sets bit 0, and bits 3:1 read 011 for a good check sequence, 010 for a bad one, and 100 for an aborted frame.
- R7: A pool that fills without a frame end closes a block with bit 0 clear. The received length field reads 0 in that case, and otherwise gives the byte count, in bits 13:8 for the 32-byte pool and in bits 14:8 for the 128-byte pool.
- R8: In transparent mode, receive-ready latches only when a full pool has arrived. End markers are ignored, and bits 3:0 stay 0.
- R9: Receive words are popped little-endian from the first byte. The pool is released after as many pops as the count needs in whole words, and the length field then reads 0.
- R10: A received byte that arrives while the pool still holds a closed block is dropped. It sets the overflow bit (status bit 4) and latches receive-ready, and it leaves the held data unchanged. A control write with command bit 5 clears the overflow and discards the pool.
- R11: A status read returns the latched events and clears them in the same cycle, unless an event is set in that same cycle.
- R12: With mode bit 7 set, the transmitted bytes are fed into the receiver, and the end marker of a block is treated as a frame end with a good check sequence.
- R13: The interrupt output is high exactly while at least one latched event is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: command, length, mode |
| stat_re | input | 1 | Status read strobe, clears latched events |
| stat_rdata | output | 32 | Status word |
| tx_push | input | 1 | Transmit word write strobe |
| tx_wdata | input | 32 | Transmit data word |
| rx_pop | input | 1 | Receive word read strobe |
| rx_rdata | output | 32 | Receive data word at the read pointer |
| irq | output | 1 | OR of the latched events |
| line_tx_req | input | 1 | Line asks for one transmit byte |
| line_tx_vld | output | 1 | Transmit byte valid |
| line_tx_byte | output | 8 | Transmit byte |
| line_tx_end | output | 1 | Transmit byte closes a frame |
| line_rx_vld | input | 1 | Received byte valid |
| line_rx_byte | input | 8 | Received byte |
| line_rx_end | input | 1 | Received byte closes a frame |
| line_rx_crc_ok | input | 1 | Frame check sequence good, read with the end marker |
| line_rx_abort | input | 1 | Frame aborted, read with the end marker |

## Verification
Some properties are checked on every cycle by the assertions. An underrun-halted transmitter stays silent. A block being sent never runs past its length. The receive overflow flag holds until a receiver reset. A held receive block is always between one byte and one pool long. A read that coincides with no new event always clears transmit-ready. The scenarios cover the rest. Only those sequences show the byte order on the line and in popped words, the zero-means-full length coding in both pool sizes, and the exact check-sequence codes. They also show that overflow leaves the held data unchanged, and the loopback path.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
   // byte-count width shared by length fields (pools up to 128 bytes)
   localparam int unsigned LEN_W = 8;

   // command bits (control byte 0)
   localparam int unsigned CMD_END_BIT  = 0;
   localparam int unsigned CMD_RXRST    = 5;
   localparam int unsigned CMD_TXRST    = 7;

   // mode bits (control byte 2)
   localparam int unsigned MODE_TRANS   = 1;
   localparam int unsigned MODE_BIG     = 5;
   localparam int unsigned MODE_LOOP    = 7;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_FILL = 2'd1,
      TX_SEND = 2'd2,
      TX_HALT = 2'd3
   } tx_state_e;
endpackage

// File: rtl/hcf_tx.sv
module hcf_tx
   import hcf_pkg::*;
#(
   parameter int unsigned POOL_MAX = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             txrst_i,
   input  logic [LEN_W-1:0] fs_i,
   input  logic [7:0]       xlen_i,
   input  logic             xend_i,
   input  logic             trans_i,
   input  logic             push_i,
   input  logic [31:0]      push_data_i,
   input  logic             req_i,
   output logic             vld_o,
   output logic [7:0]       byte_o,
   output logic             last_o,
   output logic             done_o,
   output logic             udr_o
);
   localparam int unsigned WORDS = POOL_MAX / 4;
   localparam int unsigned PTR_W = $clog2(WORDS);

   logic [31:0]      mem [WORDS];
   tx_state_e        st_q;
   logic [LEN_W-1:0] len_q, rd_q, blk_len, lm1;
   logic [PTR_W-1:0] wp_q, last_w;
   logic             blk_end_q, open_q;
   logic             vld_q, last_q, done_q, udr_q;
   logic [7:0]       byte_q;
   logic             wr_en;
   logic [PTR_W-1:0] wr_addr;
   logic [31:0]      cur_word, shifted;
   logic             stall;

   always_comb begin
      blk_len  = (xlen_i == 8'd0 || xlen_i > fs_i) ? fs_i : xlen_i;
      lm1      = len_q - LEN_W'(1);
      last_w   = lm1[PTR_W+1:2];
      stall    = req_i && open_q;
      wr_en    = push_i && !txrst_i &&
                 ((st_q == TX_IDLE) || (st_q == TX_FILL && !stall));
      wr_addr  = (st_q == TX_IDLE) ? '0 : wp_q;
      cur_word = mem[rd_q[PTR_W+1:2]];
      shifted  = cur_word >> {rd_q[1:0], 3'b000};
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= push_data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= TX_IDLE;
         len_q     <= '0;
         rd_q      <= '0;
         wp_q      <= '0;
         blk_end_q <= 1'b0;
         open_q    <= 1'b0;
         vld_q     <= 1'b0;
         last_q    <= 1'b0;
         byte_q    <= '0;
         done_q    <= 1'b0;
         udr_q     <= 1'b0;
      end else begin
         vld_q  <= 1'b0;
         last_q <= 1'b0;
         done_q <= 1'b0;
         udr_q  <= 1'b0;
         if (txrst_i) begin
            st_q   <= TX_IDLE;
            open_q <= 1'b0;
            rd_q   <= '0;
            wp_q   <= '0;
            done_q <= 1'b1;
         end else begin
            unique case (st_q)
               TX_IDLE: begin
                  if (push_i) begin
                     len_q     <= blk_len;
                     blk_end_q <= xend_i && !trans_i;
                     rd_q      <= '0;
                     wp_q      <= PTR_W'(1);
                     st_q      <= (blk_len <= LEN_W'(4)) ? TX_SEND : TX_FILL;
                  end else if (stall) begin
                     udr_q <= 1'b1;
                     st_q  <= TX_HALT;
                  end
               end
               TX_FILL: begin
                  if (stall) begin
                     udr_q <= 1'b1;
                     st_q  <= TX_HALT;
                  end else if (push_i) begin
                     wp_q <= wp_q + PTR_W'(1);
                     if (wp_q == last_w) st_q <= TX_SEND;
                  end
               end
               TX_SEND: begin
                  if (req_i) begin
                     vld_q  <= 1'b1;
                     byte_q <= shifted[7:0];
                     if (rd_q == lm1) begin
                        last_q <= blk_end_q;
                        open_q <= !blk_end_q;
                        done_q <= 1'b1;
                        st_q   <= TX_IDLE;
                     end else begin
                        rd_q <= rd_q + LEN_W'(1);
                     end
                  end
               end
               TX_HALT: ;
               default: st_q <= TX_IDLE;
            endcase
         end
      end
   end

   assign vld_o  = vld_q;
   assign byte_o = byte_q;
   assign last_o = last_q;
   assign done_o = done_q;
   assign udr_o  = udr_q;

   // R5: a halted transmitter puts nothing on the line
   a_r5_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TX_HALT) |-> !vld_q);
   // R2, R3: the send pointer never leaves the armed block
   a_r3_send_in_block: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TX_SEND) |-> (len_q != '0 && rd_q < len_q));
endmodule

// File: rtl/hcf_rx.sv
module hcf_rx
   import hcf_pkg::*;
#(
   parameter int unsigned POOL_MAX = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rxrst_i,
   input  logic [LEN_W-1:0] fs_i,
   input  logic             trans_i,
   input  logic             in_vld_i,
   input  logic [7:0]       in_byte_i,
   input  logic             in_end_i,
   input  logic             in_crc_ok_i,
   input  logic             in_abort_i,
   input  logic             pop_i,
   output logic [31:0]      pop_data_o,
   output logic             held_o,
   output logic [LEN_W-1:0] len_o,
   output logic             fend_o,
   output logic [2:0]       qual_o,
   output logic             ovf_o,
   output logic             ready_o
);
   localparam int unsigned WORDS = POOL_MAX / 4;
   localparam int unsigned PTR_W = $clog2(WORDS);

   logic             held_q, fend_q, ovf_q, ready_q;
   logic [LEN_W-1:0] cnt_q, len_q, lm1;
   logic [PTR_W-1:0] rd_q, last_w;
   logic [2:0]       qual_q;
   logic             wr_en, full, fin;

   always_comb begin
      lm1    = len_q - LEN_W'(1);
      last_w = lm1[PTR_W+1:2];
      wr_en  = in_vld_i && !held_q && !rxrst_i;
      full   = (cnt_q == fs_i - LEN_W'(1));
      fin    = !trans_i && in_end_i;
   end

   for (genvar g = 0; g < 4; g++) begin : g_lane
      logic [7:0] lane_mem [WORDS];
      always_ff @(posedge clk) begin
         if (wr_en && cnt_q[1:0] == 2'(g))
            lane_mem[cnt_q[PTR_W+1:2]] <= in_byte_i;
      end
      assign pop_data_o[8*g +: 8] = lane_mem[rd_q];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q  <= 1'b0;
         cnt_q   <= '0;
         len_q   <= '0;
         rd_q    <= '0;
         fend_q  <= 1'b0;
         qual_q  <= '0;
         ovf_q   <= 1'b0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= 1'b0;
         if (rxrst_i) begin
            held_q <= 1'b0;
            cnt_q  <= '0;
            len_q  <= '0;
            rd_q   <= '0;
            fend_q <= 1'b0;
            qual_q <= '0;
            ovf_q  <= 1'b0;
         end else if (held_q) begin
            if (in_vld_i) begin
               ovf_q   <= 1'b1;
               ready_q <= 1'b1;
            end
            if (pop_i) begin
               if (rd_q == last_w) begin
                  held_q <= 1'b0;
                  rd_q   <= '0;
                  cnt_q  <= '0;
                  len_q  <= '0;
                  fend_q <= 1'b0;
                  qual_q <= '0;
               end else begin
                  rd_q <= rd_q + PTR_W'(1);
               end
            end
         end else if (in_vld_i) begin
            if (full || fin) begin
               held_q  <= 1'b1;
               len_q   <= cnt_q + LEN_W'(1);
               ready_q <= 1'b1;
               fend_q  <= fin;
               qual_q  <= fin ? {in_abort_i, !in_abort_i, in_crc_ok_i && !in_abort_i} : 3'b000;
            end else begin
               cnt_q <= cnt_q + LEN_W'(1);
            end
         end
      end
   end

   assign held_o  = held_q;
   assign len_o   = len_q;
   assign fend_o  = fend_q;
   assign qual_o  = qual_q;
   assign ovf_o   = ovf_q;
   assign ready_o = ready_q;

   // R10: overflow stays flagged until the receiver is reset
   a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !rxrst_i) |=> ovf_q);
   // R7: a held block holds between one byte and one full pool
   a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      held_q |-> (len_q != '0 && len_q <= LEN_W'(POOL_MAX)));
   // R9: the final pop of a block releases the pool
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && pop_i && !rxrst_i && rd_q == last_w) |=> !held_q);
endmodule

// File: rtl/hdlc_chan_fifo.sv
module hdlc_chan_fifo
   import hcf_pkg::*;
#(
   parameter int unsigned SMALL_BYTES  = 32,
   parameter int unsigned LARGE_BYTES  = 128,
   parameter logic [3:0]  HW_VERSION   = 4'h2,
   parameter bit          HAS_LOOPBACK = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctrl_we,
   input  logic [31:0] ctrl_wdata,
   input  logic        stat_re,
   output logic [31:0] stat_rdata,
   input  logic        tx_push,
   input  logic [31:0] tx_wdata,
   input  logic        rx_pop,
   output logic [31:0] rx_rdata,
   output logic        irq,
   input  logic        line_tx_req,
   output logic        line_tx_vld,
   output logic [7:0]  line_tx_byte,
   output logic        line_tx_end,
   input  logic        line_rx_vld,
   input  logic [7:0]  line_rx_byte,
   input  logic        line_rx_end,
   input  logic        line_rx_crc_ok,
   input  logic        line_rx_abort
);
   localparam logic [LEN_W-1:0] FS_SMALL = LEN_W'(SMALL_BYTES);
   localparam logic [LEN_W-1:0] FS_LARGE = LEN_W'(LARGE_BYTES);

   if (LARGE_BYTES > 128 || SMALL_BYTES > LARGE_BYTES || SMALL_BYTES < 4 ||
       (SMALL_BYTES % 4) != 0 || (LARGE_BYTES % 4) != 0 ||
       (LARGE_BYTES & (LARGE_BYTES - 1)) != 0) begin : g_bad_params
      $error("hdlc_chan_fifo: pool sizes must be multiples of 4, small <= large <= 128, large a power of two");
   end

   logic [7:0]       xlen_q, mode_q;
   logic             xend_q;
   logic             txrst, rxrst, trans;
   logic [LEN_W-1:0] fs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xlen_q <= '0;
         xend_q <= 1'b0;
         mode_q <= '0;
      end else if (ctrl_we) begin
         xend_q <= ctrl_wdata[CMD_END_BIT];
         xlen_q <= ctrl_wdata[15:8];
         mode_q <= ctrl_wdata[23:16];
      end
   end

   assign txrst = ctrl_we && ctrl_wdata[CMD_TXRST];
   assign rxrst = ctrl_we && ctrl_wdata[CMD_RXRST];
   assign trans = mode_q[MODE_TRANS];
   assign fs    = mode_q[MODE_BIG] ? FS_LARGE : FS_SMALL;

   logic tx_vld, tx_last, tx_done, tx_udr;
   logic [7:0] tx_byte;

   hcf_tx #(.POOL_MAX(LARGE_BYTES)) u_tx (
      .clk(clk), .rst_n(rst_n), .txrst_i(txrst), .fs_i(fs),
      .xlen_i(xlen_q), .xend_i(xend_q), .trans_i(trans),
      .push_i(tx_push), .push_data_i(tx_wdata), .req_i(line_tx_req),
      .vld_o(tx_vld), .byte_o(tx_byte), .last_o(tx_last),
      .done_o(tx_done), .udr_o(tx_udr)
   );

   assign line_tx_vld  = tx_vld;
   assign line_tx_byte = tx_byte;
   assign line_tx_end  = tx_last;

   logic       rin_vld, rin_end, rin_crc, rin_abort;
   logic [7:0] rin_byte;

   if (HAS_LOOPBACK) begin : g_loop
      logic loop;
      assign loop      = mode_q[MODE_LOOP];
      assign rin_vld   = loop ? tx_vld  : line_rx_vld;
      assign rin_byte  = loop ? tx_byte : line_rx_byte;
      assign rin_end   = loop ? tx_last : line_rx_end;
      assign rin_crc   = loop ? 1'b1    : line_rx_crc_ok;
      assign rin_abort = loop ? 1'b0    : line_rx_abort;
   end else begin : g_direct
      assign rin_vld   = line_rx_vld;
      assign rin_byte  = line_rx_byte;
      assign rin_end   = line_rx_end;
      assign rin_crc   = line_rx_crc_ok;
      assign rin_abort = line_rx_abort;
   end

   logic             rx_held, rx_fend, rx_ovf, rx_ready;
   logic [LEN_W-1:0] rx_len;
   logic [2:0]       rx_qual;

   hcf_rx #(.POOL_MAX(LARGE_BYTES)) u_rx (
      .clk(clk), .rst_n(rst_n), .rxrst_i(rxrst), .fs_i(fs), .trans_i(trans),
      .in_vld_i(rin_vld), .in_byte_i(rin_byte), .in_end_i(rin_end),
      .in_crc_ok_i(rin_crc), .in_abort_i(rin_abort),
      .pop_i(rx_pop), .pop_data_o(rx_rdata), .held_o(rx_held),
      .len_o(rx_len), .fend_o(rx_fend), .qual_o(rx_qual),
      .ovf_o(rx_ovf), .ready_o(rx_ready)
   );

   logic xpr_q, xdu_q, rpr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xpr_q <= 1'b1;
         xdu_q <= 1'b0;
         rpr_q <= 1'b0;
      end else begin
         xpr_q <= tx_done  || (xpr_q && !stat_re);
         xdu_q <= tx_udr   || (xdu_q && !stat_re);
         rpr_q <= rx_ready || (rpr_q && !stat_re);
      end
   end

   logic [6:0] len_field;
   assign len_field  = (rx_len == fs) ? 7'd0 : rx_len[6:0];
   assign stat_rdata = {4'h0, HW_VERSION, 9'h000, len_field,
                        xpr_q, xdu_q, rpr_q, rx_ovf, rx_qual, rx_fend};
   assign irq        = xpr_q || xdu_q || rpr_q;

   // R4: a finished block always leaves transmit-ready set
   a_r4_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> xpr_q);
   // R11: a read with no new completion clears transmit-ready
   a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_re && !tx_done) |=> !xpr_q);
   // R6: the frame-end bit only appears with a held block
   a_r6_end_needs_block: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fend |-> rx_held);
endmodule

// File: tb/hdlc_chan_fifo_bench.sv
`timescale 1ns/1ps
module hdlc_chan_fifo_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [31:0] ctrl_wdata = '0;
   logic        stat_re = 1'b0;
   logic [31:0] stat_rdata;
   logic        tx_push = 1'b0;
   logic [31:0] tx_wdata = '0;
   logic        rx_pop = 1'b0;
   logic [31:0] rx_rdata;
   logic        irq;
   logic        line_tx_req = 1'b0;
   logic        line_tx_vld;
   logic [7:0]  line_tx_byte;
   logic        line_tx_end;
   logic        line_rx_vld = 1'b0;
   logic [7:0]  line_rx_byte = '0;
   logic        line_rx_end = 1'b0;
   logic        line_rx_crc_ok = 1'b0;
   logic        line_rx_abort = 1'b0;

   int checks = 0;
   int errors = 0;
   logic [8:0] exp_q[$];

   always #2 clk = ~clk;

   hdlc_chan_fifo u_hdlc_chan_fifo (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .stat_re(stat_re), .stat_rdata(stat_rdata), .tx_push(tx_push),
      .tx_wdata(tx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata), .irq(irq),
      .line_tx_req(line_tx_req), .line_tx_vld(line_tx_vld),
      .line_tx_byte(line_tx_byte), .line_tx_end(line_tx_end),
      .line_rx_vld(line_rx_vld), .line_rx_byte(line_rx_byte),
      .line_rx_end(line_rx_end), .line_rx_crc_ok(line_rx_crc_ok),
      .line_rx_abort(line_rx_abort)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   // scoreboard monitor for the transmit line
   always @(negedge clk) begin
      if (rst_n && line_tx_vld) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R5: actual unexpected byte %h expected no output", line_tx_byte);
         end else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            if ({line_tx_end, line_tx_byte} !== e) begin
               errors++;
               $display("FAIL R3: actual %h expected %h", {line_tx_end, line_tx_byte}, e);
            end
         end
      end
   end

   task automatic wr_ctrl(input logic [31:0] w);
      ctrl_we = 1'b1; ctrl_wdata = w;
      tick;
      ctrl_we = 1'b0;
   endtask

   task automatic read_stat(output logic [31:0] s);
      stat_re = 1'b1;
      s = stat_rdata;
      tick;
      stat_re = 1'b0;
   endtask

   task automatic pop(output logic [31:0] w);
      w = rx_rdata;
      rx_pop = 1'b1;
      tick;
      rx_pop = 1'b0;
   endtask

   // driver: pushes the words and the expected line bytes into the queue
   task automatic push_tx(input int n, input int base, input bit has_end, input bit expect_out);
      for (int w = 0; w < (n + 3) / 4; w++) begin
         logic [31:0] word;
         for (int b = 0; b < 4; b++) word[8*b +: 8] = 8'(base + w*4 + b);
         tx_push = 1'b1; tx_wdata = word;
         tick;
         tx_push = 1'b0;
      end
      if (expect_out)
         for (int i = 0; i < n; i++) exp_q.push_back({has_end && (i == n - 1), 8'(base + i)});
   endtask

   task automatic reqs(input int n);
      for (int i = 0; i < n; i++) begin
         line_tx_req = 1'b1;
         tick;
      end
      line_tx_req = 1'b0;
      repeat (3) tick;
   endtask

   task automatic feed(input int n, input int base, input int end_at, input bit ok, input bit ab);
      for (int i = 0; i < n; i++) begin
         line_rx_vld = 1'b1; line_rx_byte = 8'(base + i);
         line_rx_end = (i == end_at); line_rx_crc_ok = ok; line_rx_abort = ab;
         tick;
      end
      line_rx_vld = 1'b0; line_rx_end = 1'b0;
      repeat (3) tick;
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run;
   end

   initial begin
      logic [31:0] s, w;
      repeat (3) tick;
      rst_n = 1'b1;
      tick;

      // R1, R13: reset state
      chk("R1 reset status", stat_rdata, 32'h0200_0080);
      chk("R13 irq after reset", {31'b0, irq}, 32'd1);
      read_stat(s);
      tick;
      chk("R11 cleared after read", stat_rdata & 32'hE0, 32'h0);
      chk("R13 irq quiet", {31'b0, irq}, 32'd0);

      // R2, R3, R4: framed 6-byte block with end of frame
      wr_ctrl({8'h00, 8'h01, 8'd6, 8'h01});
      push_tx(6, 'h11, 1'b1, 1'b1);
      reqs(6);
      chk("R3 framed block fully sent", exp_q.size(), 0);
      read_stat(s);
      chk("R4 ready after block", s[7:6], 2'b10);
      reqs(3);
      read_stat(s);
      chk("R5 closed frame ignores requests", s[7:6], 2'b00);

      // R3, R5: transparent full block, then underrun
      wr_ctrl({8'h00, 8'h02, 8'h00, 8'h00});
      push_tx(32, 'h80, 1'b0, 1'b1);
      reqs(32);
      chk("R3 transparent block sent", exp_q.size(), 0);
      read_stat(s);
      chk("R4 ready after transparent block", s[7], 1'b1);
      reqs(1);
      read_stat(s);
      chk("R5 underrun flagged", s[6], 1'b1);
      push_tx(4, 'h55, 1'b0, 1'b0);
      reqs(4);
      chk("R5 halted transmitter silent", exp_q.size(), 0);
      wr_ctrl({8'h00, 8'h02, 8'h00, 8'h80});
      tick;
      read_stat(s);
      chk("R4 ready after transmitter reset", s[7:6], 2'b10);

      // R2: length 0 in large mode is 128 bytes, last flagged
      wr_ctrl({8'h00, 8'h21, 8'h00, 8'h01});
      push_tx(128, 0, 1'b1, 1'b1);
      reqs(128);
      chk("R2 128-byte block sent", exp_q.size(), 0);
      read_stat(s);

      // R6, R9: small framed receive, good frame
      wr_ctrl({8'h00, 8'h01, 8'h00, 8'h00});
      feed(5, 'hA0, 4, 1'b1, 1'b0);
      read_stat(s);
      chk("R6 good frame status", {s[14:8], s[5:0]}, {7'd5, 6'b100111});
      pop(w);
      chk("R9 first word", w, 32'hA3A2A1A0);
      pop(w);
      chk("R9 second word lane0", w[7:0], 8'hA4);
      chk("R9 released", stat_rdata[14:0], 15'h0);

      // R6: aborted and bad frames
      feed(3, 'h30, 2, 1'b1, 1'b1);
      read_stat(s);
      chk("R6 aborted frame", s[3:0], 4'b1001);
      pop(w);
      feed(2, 'h40, 1, 1'b0, 1'b0);
      read_stat(s);
      chk("R6 bad check sequence", s[3:0], 4'b0101);
      pop(w);

      // R7, R10: small full pool, then overflow
      feed(32, 'h10, -1, 1'b1, 1'b0);
      read_stat(s);
      chk("R7 full small pool", {s[14:8], s[5:0]}, {7'd0, 6'b100000});
      pop(w);
      chk("R9 full pool word0", w, 32'h13121110);
      feed(1, 'hEE, -1, 1'b1, 1'b0);
      read_stat(s);
      chk("R10 overflow flagged", s[5:4], 2'b11);
      pop(w);
      chk("R10 held data kept", w, 32'h17161514);
      wr_ctrl({8'h00, 8'h01, 8'h00, 8'h20});
      tick;
      chk("R10 receiver reset clears", stat_rdata[4:0], 5'h0);
      feed(2, 'h61, 1, 1'b1, 1'b0);
      read_stat(s);
      chk("R10 pool usable after reset", s[14:8], 7'd2);
      pop(w);
      chk("R10 new frame data", w[15:0], 16'h6261);

      // R7: large framed 40-byte length
      wr_ctrl({8'h00, 8'h21, 8'h00, 8'h00});
      feed(40, 'h40, 39, 1'b1, 1'b0);
      read_stat(s);
      chk("R7 large length field", s[14:8], 7'd40);
      for (int i = 0; i < 10; i++) pop(w);
      chk("R9 large last word", w, 32'h67666564);

      // R8: transparent large, end marker ignored
      wr_ctrl({8'h00, 8'h22, 8'h00, 8'h00});
      feed(11, 0, 10, 1'b1, 1'b0);
      read_stat(s);
      chk("R8 end marker ignored", s[5], 1'b0);
      feed(117, 11, -1, 1'b1, 1'b0);
      read_stat(s);
      chk("R8 full transparent pool", {s[14:8], s[5:0]}, {7'd0, 6'b100000});
      for (int i = 0; i < 32; i++) pop(w);
      chk("R9 transparent last word", w, 32'h7F7E7D7C);

      // R12: loopback of a framed 4-byte block
      wr_ctrl({8'h00, 8'h81, 8'h04, 8'h01});
      push_tx(4, 'hAA, 1'b1, 1'b1);
      reqs(4);
      repeat (2) tick;
      read_stat(s);
      chk("R12 loopback frame status", {s[14:8], s[5:0]}, {7'd4, 6'b100111});
      pop(w);
      chk("R12 loopback data", w, 32'hADACABAA);
      tick;
      chk("R13 irq low after read", {31'b0, irq}, 32'd0);

      finish_run;
   end
endmodule